// File: doc/BRIEF.md
# Scrolling Tile Background Pixel Generator

This block turns a screen coordinate into a background colour. It takes a screen pixel position, two scroll offsets and a fill colour. It then walks three lookup memories in turn. First it reads the tile map for the 8-bit character code that covers the pixel. Next it reads that character's image data for the 2-bit pixel index. Last it reads that character's own four-colour palette for a 16-bit ARGB1555 colour. When the colour found has its alpha bit set, the fill colour is emitted in its place.

The background plane is 512x512 pixels, built from a 64x64 grid of 8x8 characters. The display shows a 400x300 window of it. The screen position plus the scroll offsets, taken modulo 512 on each axis, picks the plane pixel. This lets the window scroll forever in any direction.

Each of the three memories is external and synchronous, with one cycle of read latency. The block issues one address per memory per cycle, so a new coordinate can be accepted every clock. All widths are parameters. The defaults are a 9-bit plane coordinate, 8x8 cells, 8-bit codes, 2 bits per pixel and 16-bit colour.

Top module: `bgtile_pixgen`

## Requirements
- R1: A coordinate presented with `in_valid` high in cycle n gives `out_valid` high with its colour in cycle n+3. `out_valid` is never high in a cycle whose coordinate slot three cycles earlier was empty.
- R2: In the same cycle as the coordinate, `map_addr` equals tile_row*64 + tile_col. Here tile_col = plane_x[8:3] and tile_row = plane_y[8:3].
- R3: One cycle after the coordinate, `chr_addr` equals code*16 + (plane_y mod 8)*2 + plane_x[2]. Here code is the byte returned for the map read.
- R4: Inside an image byte, the pixel with plane_x mod 4 = 0 is bits 7:6. The pixel with mod 4 = 1 is bits 5:4, mod 4 = 2 is bits 3:2, and mod 4 = 3 is bits 1:0.
- R5: Two cycles after the coordinate, `pal_addr` (a 16-bit word address) equals code*4 + pixel_index.
- R6: When bit 15 of the palette word returned is 0, `out_color` equals that word exactly.
- R7: When bit 15 of the palette word returned is 1, `out_color` equals `bg_color` as presented in the output cycle.
- R8: plane_x = (scr_x + scroll_x) mod 512 and plane_y = (scr_y + scroll_y) mod 512, so any scroll value from 0 to 511 wraps cleanly.
- R9: Coordinates and scroll values may change every cycle. Each result depends only on the scroll values presented with its own coordinate.
- R10: During and after reset, and in any cycle where `out_valid` is low, `out_color` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coordinate present this cycle |
| scr_x | input | 9 | Screen column, 0-399 |
| scr_y | input | 9 | Screen row, 0-299 |
| scroll_x | input | 9 | Horizontal plane offset, 0-511 |
| scroll_y | input | 9 | Vertical plane offset, 0-511 |
| bg_color | input | 16 | Fill colour used for transparent entries |
| map_addr | output | 12 | Tile map read address |
| map_rd_data | input | 8 | Character code, one cycle after `map_addr` |
| chr_addr | output | 12 | Character image read address (byte) |
| chr_rd_data | input | 8 | Image byte, one cycle after `chr_addr` |
| pal_addr | output | 10 | Palette read address (16-bit word) |
| pal_rd_data | input | 16 | Palette colour, one cycle after `pal_addr` |
| out_valid | output | 1 | Colour on `out_color` is valid |
| out_color | output | 16 | ARGB1555 background colour |

## Verification
The assertions check four things every cycle. They check the valid pipeline's three-cycle spacing. They check that the image row follows the previous cycle's vertical position. They check that the palette code follows the previous cycle's map data. They check that a transparent palette word yields the fill colour and that idle cycles yield zero.

The bench's sweeps are needed for the rest. That covers the wraparound of the scroll sums and the left-to-right lane order inside an image byte. It also covers the exact map and image address arithmetic, and scroll values that change every cycle. For these, the bench uses memory contents that depend on the address, and computes every expected colour arithmetically from the screen position and scroll.

// File: rtl/bgt_pkg.sv
package bgt_pkg;

   localparam int unsigned BYTE_W = 8;

   // bit offset of pixel lane 'lane' in a byte; lane 0 is the leftmost
   // pixel and occupies the most significant bits
   function automatic int unsigned lane_shift(input int unsigned lane,
                                              input int unsigned bpp,
                                              input int unsigned lanes);
      return (lanes - 1 - lane) * bpp;
   endfunction

endpackage

// File: rtl/bgt_coord.sv
// Stage 0: wrap the screen position into the plane and address the tile map.
module bgt_coord #(
   parameter  int unsigned PLANE_LOG2 = 9,
   parameter  int unsigned CELL_LOG2  = 3,
   parameter  int unsigned SCR_W      = 9,
   localparam int unsigned GRID_LOG2  = PLANE_LOG2 - CELL_LOG2,
   localparam int unsigned MAP_AW     = 2 * GRID_LOG2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [SCR_W-1:0]      scr_x,
   input  logic [SCR_W-1:0]      scr_y,
   input  logic [PLANE_LOG2-1:0] scroll_x,
   input  logic [PLANE_LOG2-1:0] scroll_y,
   output logic [MAP_AW-1:0]     map_addr,
   output logic                  s1_valid,
   output logic [CELL_LOG2-1:0]  s1_row,
   output logic [CELL_LOG2-1:0]  s1_col
);

   logic [PLANE_LOG2-1:0] plane_x;
   logic [PLANE_LOG2-1:0] plane_y;

   // same-width add drops the carry: modulo-plane wrap
   assign plane_x = scroll_x + PLANE_LOG2'(scr_x);
   assign plane_y = scroll_y + PLANE_LOG2'(scr_y);

   // row-major tile grid: row index in the upper half of the address
   assign map_addr = {plane_y[PLANE_LOG2-1:CELL_LOG2],
                      plane_x[PLANE_LOG2-1:CELL_LOG2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_row   <= '0;
         s1_col   <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_row   <= plane_y[CELL_LOG2-1:0];
         s1_col   <= plane_x[CELL_LOG2-1:0];
      end
   end

endmodule

// File: rtl/bgt_chr_fetch.sv
// Stage 1: combine the returned code with the in-cell position into an image address.
module bgt_chr_fetch #(
   parameter  int unsigned CODE_W    = 8,
   parameter  int unsigned CELL_LOG2 = 3,
   parameter  int unsigned BPP       = 2,
   localparam int unsigned BPP_LOG2  = $clog2(BPP),
   localparam int unsigned ROWB_LOG2 = CELL_LOG2 + BPP_LOG2 - 3,
   localparam int unsigned LANE_W    = CELL_LOG2 - ROWB_LOG2,
   localparam int unsigned LANE_EW   = (LANE_W == 0) ? 1 : LANE_W,
   localparam int unsigned CHR_AW    = CODE_W + CELL_LOG2 + ROWB_LOG2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 s1_valid,
   input  logic [CELL_LOG2-1:0] s1_row,
   input  logic [CELL_LOG2-1:0] s1_col,
   input  logic [CODE_W-1:0]    map_data,
   output logic [CHR_AW-1:0]    chr_addr,
   output logic                 s2_valid,
   output logic [CODE_W-1:0]    s2_code,
   output logic [LANE_EW-1:0]   s2_lane
);

   logic [LANE_EW-1:0] lane_next;

   // one image row spans 2^ROWB_LOG2 bytes; upper column bits pick the byte
   if (ROWB_LOG2 == 0) begin : g_one_byte_row
      assign chr_addr = {map_data, s1_row};
   end else begin : g_multi_byte_row
      assign chr_addr = {map_data, s1_row, s1_col[CELL_LOG2-1 -: ROWB_LOG2]};
   end

   // low column bits pick the lane inside the byte
   if (LANE_W == 0) begin : g_no_lane
      assign lane_next = '0;
   end else begin : g_lane
      assign lane_next = s1_col[LANE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_code  <= '0;
         s2_lane  <= '0;
      end else begin
         s2_valid <= s1_valid;
         s2_code  <= map_data;
         s2_lane  <= lane_next;
      end
   end

endmodule

// File: rtl/bgt_pal_stage.sv
// Stage 2: extract the pixel index, address the palette, resolve transparency.
module bgt_pal_stage #(
   parameter  int unsigned CODE_W  = 8,
   parameter  int unsigned BPP     = 2,
   parameter  int unsigned COLOR_W = 16,
   localparam int unsigned LANES   = bgt_pkg::BYTE_W / BPP,
   localparam int unsigned LANE_W  = $clog2(LANES),
   localparam int unsigned LANE_EW = (LANE_W == 0) ? 1 : LANE_W,
   localparam int unsigned PAL_AW  = CODE_W + BPP
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      s2_valid,
   input  logic [CODE_W-1:0]         s2_code,
   input  logic [LANE_EW-1:0]        s2_lane,
   input  logic [bgt_pkg::BYTE_W-1:0] chr_data,
   output logic [PAL_AW-1:0]         pal_addr,
   input  logic [COLOR_W-1:0]        pal_data,
   input  logic [COLOR_W-1:0]        bg_color,
   output logic                      out_valid,
   output logic [COLOR_W-1:0]        out_color
);

   logic [BPP-1:0] lane_pix [LANES];
   logic [BPP-1:0] pix;
   logic           s3_valid;

   for (genvar g = 0; g < LANES; g++) begin : g_lane_split
      assign lane_pix[g] = chr_data[bgt_pkg::lane_shift(g, BPP, LANES) +: BPP];
   end

   if (LANES == 1) begin : g_single_lane
      assign pix = lane_pix[0];
   end else begin : g_lane_mux
      assign pix = lane_pix[s2_lane];
   end

   assign pal_addr = {s2_code, pix};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s3_valid <= 1'b0;
      else        s3_valid <= s2_valid;
   end

   assign out_valid = s3_valid;
   always_comb begin
      if (!s3_valid)                out_color = '0;
      else if (pal_data[COLOR_W-1]) out_color = bg_color;
      else                          out_color = pal_data;
   end

   // R6: an opaque palette word reaches the output untouched
   p_opaque_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !pal_data[COLOR_W-1]) |-> (out_color == pal_data));

endmodule

// File: rtl/bgtile_pixgen.sv
module bgtile_pixgen #(
   parameter  int unsigned PLANE_LOG2 = 9,
   parameter  int unsigned CELL_LOG2  = 3,
   parameter  int unsigned SCR_W      = 9,
   parameter  int unsigned CODE_W     = 8,
   parameter  int unsigned BPP        = 2,
   parameter  int unsigned COLOR_W    = 16,
   localparam int unsigned BPP_LOG2   = $clog2(BPP),
   localparam int unsigned GRID_LOG2  = PLANE_LOG2 - CELL_LOG2,
   localparam int unsigned MAP_AW     = 2 * GRID_LOG2,
   localparam int unsigned ROWB_LOG2  = CELL_LOG2 + BPP_LOG2 - 3,
   localparam int unsigned LANE_W     = CELL_LOG2 - ROWB_LOG2,
   localparam int unsigned LANE_EW    = (LANE_W == 0) ? 1 : LANE_W,
   localparam int unsigned CHR_AW     = CODE_W + CELL_LOG2 + ROWB_LOG2,
   localparam int unsigned PAL_AW     = CODE_W + BPP
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [SCR_W-1:0]      scr_x,
   input  logic [SCR_W-1:0]      scr_y,
   input  logic [PLANE_LOG2-1:0] scroll_x,
   input  logic [PLANE_LOG2-1:0] scroll_y,
   input  logic [COLOR_W-1:0]    bg_color,
   output logic [MAP_AW-1:0]     map_addr,
   input  logic [CODE_W-1:0]     map_rd_data,
   output logic [CHR_AW-1:0]     chr_addr,
   input  logic [7:0]            chr_rd_data,
   output logic [PAL_AW-1:0]     pal_addr,
   input  logic [COLOR_W-1:0]    pal_rd_data,
   output logic                  out_valid,
   output logic [COLOR_W-1:0]    out_color
);

   // elaboration-time parameter checks
   if (!(BPP == 1 || BPP == 2 || BPP == 4 || BPP == 8)) begin : g_bad_bpp
      $error("bgtile_pixgen: BPP must be 1, 2, 4 or 8");
   end
   if (CELL_LOG2 + BPP_LOG2 < 3) begin : g_bad_cell
      $error("bgtile_pixgen: a cell row must fill at least one byte");
   end
   if (CELL_LOG2 >= PLANE_LOG2) begin : g_bad_plane
      $error("bgtile_pixgen: cell must be smaller than the plane");
   end
   if (SCR_W > PLANE_LOG2) begin : g_bad_scr
      $error("bgtile_pixgen: screen coordinate wider than plane coordinate");
   end
   if (COLOR_W < 2) begin : g_bad_color
      $error("bgtile_pixgen: colour needs an alpha bit and data");
   end

   logic                 s1_valid;
   logic [CELL_LOG2-1:0] s1_row;
   logic [CELL_LOG2-1:0] s1_col;
   logic                 s2_valid;
   logic [CODE_W-1:0]    s2_code;
   logic [LANE_EW-1:0]   s2_lane;

   bgt_coord #(
      .PLANE_LOG2 (PLANE_LOG2),
      .CELL_LOG2  (CELL_LOG2),
      .SCR_W      (SCR_W)
   ) u_coord (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .scr_x    (scr_x),
      .scr_y    (scr_y),
      .scroll_x (scroll_x),
      .scroll_y (scroll_y),
      .map_addr (map_addr),
      .s1_valid (s1_valid),
      .s1_row   (s1_row),
      .s1_col   (s1_col)
   );

   bgt_chr_fetch #(
      .CODE_W    (CODE_W),
      .CELL_LOG2 (CELL_LOG2),
      .BPP       (BPP)
   ) u_chr (
      .clk      (clk),
      .rst_n    (rst_n),
      .s1_valid (s1_valid),
      .s1_row   (s1_row),
      .s1_col   (s1_col),
      .map_data (map_rd_data),
      .chr_addr (chr_addr),
      .s2_valid (s2_valid),
      .s2_code  (s2_code),
      .s2_lane  (s2_lane)
   );

   bgt_pal_stage #(
      .CODE_W  (CODE_W),
      .BPP     (BPP),
      .COLOR_W (COLOR_W)
   ) u_pal (
      .clk       (clk),
      .rst_n     (rst_n),
      .s2_valid  (s2_valid),
      .s2_code   (s2_code),
      .s2_lane   (s2_lane),
      .chr_data  (chr_rd_data),
      .pal_addr  (pal_addr),
      .pal_data  (pal_rd_data),
      .bg_color  (bg_color),
      .out_valid (out_valid),
      .out_color (out_color)
   );

   // R1: a valid colour always traces back to a coordinate three cycles earlier
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 3));

   // R3: image row field follows the vertical position of the previous cycle
   p_chr_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> (chr_addr[ROWB_LOG2 +: CELL_LOG2] ==
                    $past(CELL_LOG2'(scr_y) + CELL_LOG2'(scroll_y))));

   // R5: palette block index is the code the map returned one cycle before
   p_pal_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      s2_valid |-> (pal_addr[PAL_AW-1 -: CODE_W] == $past(map_rd_data)));

   // R7: transparent palette word yields the fill colour
   p_bg_subst_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && pal_rd_data[COLOR_W-1]) |-> (out_color == bg_color));

   // R10: idle slots drive zero
   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_color == '0));

endmodule

// File: tb/bgtile_pixgen_test.sv
`timescale 1ns/1ps
module bgtile_pixgen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [8:0]  scr_x = '0, scr_y = '0, scroll_x = '0, scroll_y = '0;
   logic [15:0] bg_color = 16'h0000;
   logic [11:0] map_addr, chr_addr;
   logic [9:0]  pal_addr;
   logic [7:0]  map_q = '0, chr_q = '0;
   logic [15:0] pal_q = '0;
   logic        out_valid;
   logic [15:0] out_color;

   int  nchk = 0;
   int  nfail = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   bgtile_pixgen uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .scr_x(scr_x), .scr_y(scr_y), .scroll_x(scroll_x), .scroll_y(scroll_y),
      .bg_color(bg_color),
      .map_addr(map_addr), .map_rd_data(map_q),
      .chr_addr(chr_addr), .chr_rd_data(chr_q),
      .pal_addr(pal_addr), .pal_rd_data(pal_q),
      .out_valid(out_valid), .out_color(out_color)
   );

   // address-dependent memory contents
   function automatic logic [7:0] mfn(input logic [11:0] a);
      int v = int'(a);
      return 8'(v * 73 + (v >> 6) * 13);
   endfunction
   function automatic logic [7:0] cfn(input logic [11:0] a);
      int v = int'(a);
      return 8'((v * 151) ^ (v >> 5));
   endfunction
   function automatic logic [15:0] pfn(input logic [9:0] a);
      int v = int'(a);
      return {(v % 5 == 1), 15'(v * 389 + 17)};
   endfunction

   // synchronous memories, one cycle read latency
   always @(posedge clk) begin
      map_q <= mfn(map_addr);
      chr_q <= cfn(chr_addr);
      pal_q <= pfn(pal_addr);
   end

   task automatic chk(input bit ok, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   // arithmetic reference: R8 wrap, R2 map, R3 image, R4 lane, R5 palette, R6/R7
   task automatic model(input int sx, input int sy, input int scx, input int scy,
                        input logic [15:0] bg, output logic [15:0] col,
                        output bit alpha, output int ma, output int ca, output int pa);
      int x, y, code, b, pix;
      logic [15:0] w;
      x    = (sx + scx) % 512;
      y    = (sy + scy) % 512;
      ma   = (y / 8) * 64 + x / 8;
      code = int'(mfn(12'(ma)));
      ca   = code * 16 + (y % 8) * 2 + (x % 8) / 4;
      b    = int'(cfn(12'(ca)));
      pix  = (b >> (6 - 2 * (x % 4))) & 3;
      pa   = code * 4 + pix;
      w    = pfn(10'(pa));
      alpha = w[15];
      col  = w[15] ? bg : w;
   endtask

   bit          ev [3];
   bit          ea [3];
   logic [15:0] ec [3];
   int          eca[3];
   int          epa[3];
   string       etg[3];

   task automatic step(input bit v, input int sx, input int sy,
                       input int scx, input int scy, input string tag);
      logic [15:0] col;
      bit al;
      int ma, ca, pa;
      @(negedge clk);
      // R1: valid appears exactly three cycles after its coordinate
      chk(out_valid == ev[2], {"R1 out_valid timing ", etg[2]},
          32'(out_valid), 32'(ev[2]));
      if (ev[2])
         chk(out_color == ec[2], {ea[2] ? "R7 fill colour " : "R6 palette colour ", etg[2]},
             32'(out_color), 32'(ec[2]));
      else
         chk(out_color == 16'h0, "R10 idle colour", 32'(out_color), 32'h0);
      if (ev[0])
         chk(chr_addr == 12'(eca[0]), {"R3 image address ", etg[0]},
             32'(chr_addr), 32'(eca[0]));
      if (ev[1])
         chk(pal_addr == 10'(epa[1]), {"R5 palette address ", etg[1]},
             32'(pal_addr), 32'(epa[1]));
      for (int i = 2; i > 0; i--) begin
         ev[i] = ev[i-1]; ea[i] = ea[i-1]; ec[i] = ec[i-1];
         eca[i] = eca[i-1]; epa[i] = epa[i-1]; etg[i] = etg[i-1];
      end
      in_valid = v;
      scr_x = 9'(sx); scr_y = 9'(sy); scroll_x = 9'(scx); scroll_y = 9'(scy);
      model(sx, sy, scx, scy, bg_color, col, al, ma, ca, pa);
      ev[0] = v; ea[0] = al; ec[0] = col; eca[0] = ca; epa[0] = pa; etg[0] = tag;
      #1;
      if (v) chk(map_addr == 12'(ma), {"R2 map address ", tag}, 32'(map_addr), 32'(ma));
   endtask

   task automatic flush();
      for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, 0, "idle");
   endtask

   initial begin
      int scx_l[5] = '{0, 3, 137, 511, 300};
      int scy_l[5] = '{0, 5, 455, 511, 400};
      logic [15:0] bg_l[5] = '{16'h7c1f, 16'h03e0, 16'h1234, 16'h7fff, 16'h0001};
      int rows[6] = '{0, 1, 7, 8, 150, 299};
      int idx = 0;
      for (int i = 0; i < 3; i++) begin
         ev[i] = 1'b0; ea[i] = 1'b0; ec[i] = '0; eca[i] = 0; epa[i] = 0; etg[i] = "";
      end
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(out_valid == 1'b0, "R10 reset out_valid", 32'(out_valid), 32'h0);
      chk(out_color == 16'h0, "R10 reset out_color", 32'(out_color), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4 R6 R7 R9: full rows under several scroll settings, with idle gaps
      for (int s = 0; s < 5; s++) begin
         bg_color = bg_l[s];
         foreach (rows[r]) begin
            for (int x = 0; x < 400; x++) begin
               idx++;
               if (idx % 13 == 0) step(1'b0, 0, 0, 0, 0, "gap");
               step(1'b1, x, rows[r], scx_l[s], scy_l[s], "R9 R4 row sweep");
            end
         end
         flush();
      end

      // R2 R3: full columns at both screen edges
      bg_color = 16'h2a55;
      for (int c = 0; c < 2; c++)
         for (int y = 0; y < 300; y++)
            step(1'b1, c * 399, y, 200, 250, "R2 R3 column sweep");
      flush();

      // R8 R9: every horizontal scroll value, changing each cycle, at the far corner
      bg_color = 16'h4411;
      for (int k = 0; k < 3; k++)
         for (int scx = 0; scx < 512; scx++)
            step(1'b1, 399, 299, scx, (k * 255) % 512 + (k == 2 ? 1 : 0), "R8 wrap sweep");
      flush();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: run did not complete act=0 exp=1");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

endmodule